// File: doc/BRIEF.md
# Flag-Generating ALU

This block is the combinational arithmetic and logic unit of a small 8-bit core. It takes two register operands and a 3-bit operation code and returns a result byte. It also returns a five-bit flag vector and a five-bit update mask. The register file copies a flag from the vector only where the matching mask bit is set, and every other flag keeps its previous value. A separate write-enable tells the register file whether the result should be written to the destination register.

Arithmetic operations (add, subtract, compare) produce all five flags. Bitwise and shift operations (and, or, not, logical right shift) produce only the zero, sign and less-than flags. Compare computes the difference only so that its flags can be used, and it leaves the destination register untouched. The block has no state, no clock and no reset. Writeback, sequencing and memory access are handled by its neighbours.

Top module: `alu_flags`

## Requirements
- R1: Code 0 (add) gives result = (x + y) mod 256, and C (flag bit 0) = carry out of bit 7.
- R2: Code 1 (subtract) gives result = (x − y) mod 256, and C = 1 exactly when x < y as unsigned numbers (borrow).
- R3: Code 2 (compare) drives the same result and flags as subtract for the same operands.
- R4: For every code from 0 to 6, Z (flag bit 1) is 1 exactly when the 8-bit result is zero, and S (flag bit 2) equals result bit 7.
- R5: For codes 0 to 2, O (flag bit 3) is the two's-complement overflow of the signed add or subtract.
- R6: L (flag bit 4) equals S XOR O for codes 0 to 2, and equals S for codes 3 to 6.
- R7: The mask is 5'b11111 for codes 0 to 2 and 5'b10110 (Z, S, L) for codes 3 to 6. Flag bits outside the mask are driven 0.
- R8: Code 3 gives x & y and code 4 gives x | y. Code 5 gives ~x, and y has no effect on its outputs.
- R9: Code 6 gives x shifted right logically by y bit positions, and any y of 8 or more gives 0.
- R10: result_we is 1 for codes 0, 1, 3, 4, 5 and 6, and 0 for code 2.
- R11: Code 7 is reserved. It drives result, flags, mask and result_we all to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 not, 6 rsh, 7 reserved) |
| opnd_x | input | 8 | First operand, also the destination operand |
| opnd_y | input | 8 | Second operand, or the shift amount |
| result | output | 8 | Operation result |
| flags | output | 5 | Flag values {L, O, S, Z, C} |
| flag_mask | output | 5 | Per-flag update enable, same bit order as flags |
| result_we | output | 1 | Result should be written to the destination register |

## Verification
Every operation code is swept over all 65,536 operand pairs. This covers the carry and borrow edges (0xFF + 0x01, 0x00 − 0x01), the signed overflow corners around 0x7F and 0x80, and a zero result reached from nonzero operands. A design that took C as the raw adder carry on subtract would report a borrow inverted from the unsigned comparison. A design with only one overflow rule would be wrong for one of the two operations. Shift amounts from 8 to 255 are covered, so a design that kept only the low three bits of y would return a nonzero value there. The compare and reserved codes are checked for no result write and, for code 7, for an all-zero mask, which catches a design that lets them fall through to another operation.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_NOT = 3'd5,
    OP_RSH = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BIT_AND = 2'd0,
    BIT_OR  = 2'd1,
    BIT_NOT = 2'd2,
    BIT_RSH = 2'd3
  } bit_op_e;

  localparam int FLAG_W = 5;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FS = 2;
  localparam int FO = 3;
  localparam int FL = 4;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 5'b11111;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 5'b10110;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
    sum   = wide[W-1:0];
    // Subtract reports a borrow, which is the inverse of the adder carry.
    carry = do_sub ? ~wide[W] : wide[W];
    // Overflow: both effective operands agree in sign and the sum does not.
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  bit_op_e      sel,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] SHIFT_LIM = W[W-1:0];

  logic [W-1:0] shifted;

  always_comb begin
    shifted = (b >= SHIFT_LIM) ? '0 : (a >> b);
    unique case (sel)
      BIT_AND: res = a & b;
      BIT_OR:  res = a | b;
      BIT_NOT: res = ~a;
      default: res = shifted;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      opnd_x,
  input  logic [W-1:0]      opnd_y,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] flag_mask,
  output logic              result_we
);

  alu_op_e      op;
  logic         is_arith;
  logic         is_logic;
  logic         do_sub;
  bit_op_e      bsel;
  logic [W-1:0] as_sum;
  logic         as_carry;
  logic         as_ovf;
  logic [W-1:0] bo_res;
  logic [W-1:0] res_int;
  logic         z_f;
  logic         s_f;

  always_comb begin
    op       = alu_op_e'(op_sel);
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_NOT) || (op == OP_RSH);
    do_sub   = (op != OP_ADD);
    unique case (op)
      OP_AND:  bsel = BIT_AND;
      OP_OR:   bsel = BIT_OR;
      OP_NOT:  bsel = BIT_NOT;
      default: bsel = BIT_RSH;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a      (opnd_x),
    .b      (opnd_y),
    .do_sub (do_sub),
    .sum    (as_sum),
    .carry  (as_carry),
    .ovf    (as_ovf)
  );

  alu_bitops #(.W(W)) u_bitops (
    .a   (opnd_x),
    .b   (opnd_y),
    .sel (bsel),
    .res (bo_res)
  );

  always_comb begin
    if (is_arith)      res_int = as_sum;
    else if (is_logic) res_int = bo_res;
    else               res_int = '0;
    z_f = (res_int == '0);
    s_f = res_int[W-1];

    flags     = '0;
    flag_mask = '0;
    result_we = 1'b0;
    if (is_arith) begin
      flags[FC] = as_carry;
      flags[FZ] = z_f;
      flags[FS] = s_f;
      flags[FO] = as_ovf;
      flags[FL] = s_f ^ as_ovf;
      flag_mask = MASK_ARITH;
      result_we = (op != OP_CMP);
    end else if (is_logic) begin
      flags[FZ] = z_f;
      flags[FS] = s_f;
      flags[FL] = s_f;
      flag_mask = MASK_LOGIC;
      result_we = 1'b1;
    end
    result = res_int;
  end

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 8
) (
  input logic [2:0]   op_sel,
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [W-1:0] result,
  input logic [4:0]   flags,
  input logic [4:0]   flag_mask,
  input logic         result_we
);

  always_comb begin
    assert_mask_shape_R7: assert (flag_mask == 5'b11111 || flag_mask == 5'b10110 || flag_mask == 5'b00000)
      else $error("mask shape %b", flag_mask);
    assert_unmasked_zero_R7: assert ((flags & ~flag_mask) == 5'b00000)
      else $error("flag outside mask %b/%b", flags, flag_mask);
    assert_zero_flag_R4: assert (!flag_mask[1] || (flags[1] == (result == '0)))
      else $error("Z mismatch");
    assert_sign_flag_R4: assert (!flag_mask[2] || (flags[2] == result[W-1]))
      else $error("S mismatch");
    assert_less_flag_R6: assert (!flag_mask[4] || (flags[4] == (flags[2] ^ flags[3])))
      else $error("L mismatch");
    assert_cmp_no_write_R10: assert (!(op_sel == 3'd2) || !result_we)
      else $error("cmp writes result");
    assert_reserved_idle_R11: assert (!(op_sel == 3'd7) || (result == '0 && flag_mask == '0 && !result_we))
      else $error("reserved code active");
  end

endmodule

bind alu_flags alu_flags_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_flags.sv
`timescale 1ns/1ps
module tb_alu_flags;

  logic       clk;
  logic       rst_n;
  logic [2:0] op_sel;
  logic [7:0] opnd_x;
  logic [7:0] opnd_y;
  logic [7:0] result;
  logic [4:0] flags;
  logic [4:0] flag_mask;
  logic       result_we;

  int n_checks;
  int n_errs;
  int cycles;
  bit done;

  alu_flags dut (
    .op_sel    (op_sel),
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .result    (result),
    .flags     (flags),
    .flag_mask (flag_mask),
    .result_we (result_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycles <= 0;
    else        cycles <= cycles + 1;
  end

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errs++;
      $display("FAIL %s op=%0d x=%0d y=%0d actual=%0h expected=%0h",
               req, op_sel, opnd_x, opnd_y, got, exp);
    end
  endtask

  task automatic sweep();
    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          int sx, sy, full, er, ec, eo, ez, es, el, ef, em, ew;
          string rtag;
          op_sel = op[2:0];
          opnd_x = x[7:0];
          opnd_y = y[7:0];
          #1;
          sx = (x > 127) ? x - 256 : x;
          sy = (y > 127) ? y - 256 : y;
          ec = 0; eo = 0; em = 0; ew = 0; er = 0;
          case (op)
            0: begin full = sx + sy; er = (x + y) % 256; ec = (x + y > 255); rtag = "R1"; end
            1: begin full = sx - sy; er = (x - y + 256) % 256; ec = (x < y); rtag = "R2"; end
            2: begin full = sx - sy; er = (x - y + 256) % 256; ec = (x < y); rtag = "R3"; end
            3: begin full = 0; er = x & y; rtag = "R8"; end
            4: begin full = 0; er = x | y; rtag = "R8"; end
            5: begin full = 0; er = 255 - x; rtag = "R8"; end
            6: begin full = 0; er = (y >= 8) ? 0 : (x >> y); rtag = "R9"; end
            default: begin full = 0; er = 0; rtag = "R11"; end
          endcase
          ez = (er == 0);
          es = (er >= 128);
          if (op <= 2) begin
            eo = (full > 127 || full < -128);
            el = es ^ eo;
            em = 31;
            ew = (op != 2);
            ef = (el << 4) | (eo << 3) | (es << 2) | (ez << 1) | ec;
          end else if (op <= 6) begin
            el = es;
            em = 22;
            ew = 1;
            ef = (el << 4) | (es << 2) | (ez << 1);
          end else begin
            ef = 0;
          end
          check(rtag, int'(result), er);
          check((op == 7) ? "R11 flags" : "R4 R5 R6 flags", int'(flags), ef);
          check((op == 7) ? "R11 mask" : "R7 mask", int'(flag_mask), em);
          check((op == 7) ? "R11 we" : "R10 we", int'(result_we), ew);
        end
      end
    end
  endtask

  initial begin
    n_checks = 0;
    n_errs   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    op_sel   = 3'd7;
    opnd_x   = 8'h00;
    opnd_y   = 8'h00;
    #20;
    // Idle state with the reserved code: everything quiet (R11).
    check("R11 idle result", int'(result), 0);
    check("R11 idle mask", int'(flag_mask), 0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep();
    // Named corners on top of the sweep.
    op_sel = 3'd0; opnd_x = 8'hFF; opnd_y = 8'h01; #1;
    check("R1 carry corner", int'(flags[0]), 1);
    op_sel = 3'd1; opnd_x = 8'h80; opnd_y = 8'h01; #1;
    check("R5 sub overflow", int'(flags[3]), 1);
    op_sel = 3'd5; opnd_x = 8'h0F; opnd_y = 8'hAA; #1;
    check("R8 not ignores y", int'(result), 8'hF0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000 || done);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule